// File: doc/BRIEF.md
# Core Clock Generator with Divider and Source Switching

This block makes the clock for a processor core from two inputs: a fast clock from a PLL and a slow crystal reference clock. A first glitch-free switch picks the source that feeds a programmable divider. A second glitch-free switch sends either the divider output or the raw crystal clock to the core. The divider has a mixed ratio code. A two-bit code gives a ratio of 1, 2 or 3 directly. Its top value gives an even ratio of twice a nine-bit count.

Software controls the block through two 32-bit registers on a plain write/read port, which is clocked by the crystal. The intended retune order is as follows. Move the core onto the crystal. Retarget the source switch while the PLL settles. Then move the core back onto the divider. The core never sees a shortened pulse at any step. A ratio change lands only at the end of a divider period. A count of zero under the even-ratio code parks the divider output low.

Top module: `ccg_core_clkgen`

## Requirements
- R1: After reset both registers read zero, and `core_clk` follows `xtal_clk` (period equal to the crystal period, high for half of it).
- R2: The register at offset 0x40 holds the source bit at bit 0 (1 = PLL, 0 = crystal), the ratio code at bits [3:2] and the output bit at bit 7 (1 = divider, 0 = crystal). The register at offset 0x00 holds the count N at bits [28:20]. All other bits read zero. Other offsets read zero, and writes to them change nothing.
- R3: Ratio codes 0, 1 and 2 divide the selected source by 1, 2 and 3. For ratios 2 and 3 the output is high for one source period.
- R4: Ratio code 3 with N > 0 divides by 2N, with the output high for N source periods and low for N.
- R5: Ratio code 3 with N = 0 holds the divider output low. Writing a nonzero N later restarts it.
- R6: A new ratio takes effect only at a divider period boundary, so no core pulse is shorter than half a source period.
- R7: The source bit moves the divider input between the crystal and the PLL without a pulse shorter than half the faster clock's period.
- R8: The output bit moves `core_clk` between the crystal and the divider without a runt pulse.
- R9: In each switch, the two input enables are never on at the same time.
- R10: The retune order (output to crystal, change source, output back to divider) ends with `core_clk` at the new divided rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal reference clock; also clocks the register port |
| pll_clk | input | 1 | PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on `xtal_clk` |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| core_clk | output | 1 | Clock to the processor core |

## Verification
The assertions check four things on every cycle. Each switch's enables are mutually exclusive. The register fields follow writes to their own offset and ignore writes elsewhere. The fields are zero when reset releases. A zero ratio keeps the divider output low. Only the bench's scenarios can show the rest. It measures output period and high time for every ratio code and for several values of N, with both sources and after each retune step. It also keeps a running minimum of every high and low pulse on `core_clk`, which shows that no switch or ratio change produced a runt.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;
  // Register offsets
  localparam int unsigned CTRL_OFF  = 'h40;
  localparam int unsigned RATIO_OFF = 'h00;
  // Field positions in the control register
  localparam int unsigned SRC_BIT = 0;
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned OUT_BIT = 7;
  // Field position in the ratio register
  localparam int unsigned N_LSB   = 20;
endpackage

// File: rtl/ccg_rst_sync.sv
`timescale 1ns/1ps
module ccg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/ccg_regs.sv
`timescale 1ns/1ps
module ccg_regs
  import ccg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_W    = 9,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              src_sel,
  output logic              out_sel,
  output logic [SEL_W-1:0]  div_sel,
  output logic [N_W-1:0]    div_n
);
  logic hit_ctrl, hit_ratio, en_ctrl, en_ratio;
  logic             src_d, out_d;
  logic [SEL_W-1:0] sel_d;
  logic [N_W-1:0]   n_d;

  always_comb begin
    hit_ctrl  = (addr == ADDR_W'(CTRL_OFF));
    hit_ratio = (addr == ADDR_W'(RATIO_OFF));
    en_ctrl   = wr && hit_ctrl;
    en_ratio  = wr && hit_ratio;
    src_d     = wdata[SRC_BIT];
    out_d     = wdata[OUT_BIT];
    sel_d     = wdata[SEL_LSB +: SEL_W];
    n_d       = wdata[N_LSB +: N_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= 1'b0;
      out_sel <= 1'b0;
      div_sel <= '0;
    end else if (en_ctrl) begin
      src_sel <= src_d;
      out_sel <= out_d;
      div_sel <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_n <= '0;
    else if (en_ratio) div_n <= n_d;
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl) begin
      rdata[SRC_BIT]             = src_sel;
      rdata[OUT_BIT]             = out_sel;
      rdata[SEL_LSB +: SEL_W]    = div_sel;
    end
    if (hit_ratio) rdata[N_LSB +: N_W] = div_n;
  end
endmodule

// File: rtl/ccg_clk_switch.sv
`timescale 1ns/1ps
module ccg_clk_switch #(
  parameter int STAGES = 2
) (
  input  logic       rst_n,
  input  logic       clk0,
  input  logic       clk1,
  input  logic       sel,
  output logic [1:0] en,
  output logic       clk_out
);
  logic [1:0] clk_in;
  logic [1:0] want;

  assign clk_in = {clk1, clk0};

  always_comb begin
    want[0] = !sel && !en[1];
    want[1] =  sel && !en[0];
  end

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], want[g]};

    // Enables move only while this input is low
    always_ff @(negedge clk_in[g] or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign en[g] = chain_q[STAGES-1];
  end

  assign clk_out = (clk0 & en[0]) | (clk1 & en[1]);
endmodule

// File: rtl/ccg_divider.sv
`timescale 1ns/1ps
module ccg_divider #(
  parameter int N_W    = 9,
  parameter int SEL_W  = 2,
  parameter int STAGES = 2,
  localparam int RW    = N_W + 1,
  localparam int CFG_W = SEL_W + N_W
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [N_W-1:0]   cfg_n,
  output logic             div_clk,
  output logic [RW-1:0]    ratio
);
  logic [STAGES:0][CFG_W-1:0] pipe_q, pipe_d;
  logic [CFG_W-1:0] cfg_s;
  logic [SEL_W-1:0] sel_s;
  logic [N_W-1:0]   n_s;
  logic             stable;
  logic [RW-1:0]    cand, pick, last, cnt_q, cnt_d, ratio_d;
  logic             boundary, q_q, q_d, byp_q, byp_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], {cfg_sel, cfg_n}};
    cfg_s  = pipe_q[STAGES];
    sel_s  = cfg_s[CFG_W-1 -: SEL_W];
    n_s    = cfg_s[N_W-1:0];
    stable = (pipe_q[STAGES] == pipe_q[STAGES-1]);
    if (sel_s == '1) cand = {n_s, 1'b0};
    else             cand = RW'(sel_s) + RW'(1);
    pick     = stable ? cand : ratio;
    last     = (ratio == '0) ? '0 : ratio - RW'(1);
    boundary = (cnt_q >= last);
    if (boundary) begin
      ratio_d = pick;
      cnt_d   = '0;
      q_d     = (pick >= RW'(2));
      byp_d   = (pick == RW'(1));
    end else begin
      ratio_d = ratio;
      cnt_d   = cnt_q + RW'(1);
      q_d     = (cnt_d < (ratio >> 1));
      byp_d   = byp_q;
    end
  end

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio <= RW'(1);
      cnt_q <= '0;
      q_q   <= 1'b0;
      byp_q <= 1'b1;
    end else begin
      ratio <= ratio_d;
      cnt_q <= cnt_d;
      q_q   <= q_d;
      byp_q <= byp_d;
    end
  end

  assign div_clk = byp_q ? src_clk : q_q;
endmodule

// File: rtl/ccg_core_clkgen.sv
`timescale 1ns/1ps
module ccg_core_clkgen #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int N_W         = 9,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              xtal_clk,
  input  logic              pll_clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              core_clk
);
  localparam int RW = N_W + 1;

  logic             x_rst_n, s_rst_n;
  logic             src_sel, out_sel;
  logic [SEL_W-1:0] div_sel;
  logic [N_W-1:0]   div_n;
  logic [1:0]       src_en, out_en;
  logic             src_clk, div_clk;
  logic [RW-1:0]    div_ratio;

  ccg_rst_sync #(.STAGES(SYNC_STAGES)) u_xrst (
    .clk(xtal_clk), .rst_n(rst_n), .rst_n_sync(x_rst_n));

  ccg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W), .SEL_W(SEL_W)) u_regs (
    .clk(xtal_clk), .rst_n(x_rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .src_sel(src_sel),
    .out_sel(out_sel), .div_sel(div_sel), .div_n(div_n));

  ccg_clk_switch #(.STAGES(SYNC_STAGES)) u_src_sw (
    .rst_n(rst_n), .clk0(xtal_clk), .clk1(pll_clk), .sel(src_sel),
    .en(src_en), .clk_out(src_clk));

  ccg_rst_sync #(.STAGES(SYNC_STAGES)) u_srst (
    .clk(src_clk), .rst_n(rst_n), .rst_n_sync(s_rst_n));

  ccg_divider #(.N_W(N_W), .SEL_W(SEL_W), .STAGES(SYNC_STAGES)) u_div (
    .src_clk(src_clk), .rst_n(s_rst_n), .cfg_sel(div_sel), .cfg_n(div_n),
    .div_clk(div_clk), .ratio(div_ratio));

  ccg_clk_switch #(.STAGES(SYNC_STAGES)) u_out_sw (
    .rst_n(rst_n), .clk0(xtal_clk), .clk1(div_clk), .sel(out_sel),
    .en(out_en), .clk_out(core_clk));
endmodule

// File: rtl/ccg_core_clkgen_chk.sv
`timescale 1ns/1ps
module ccg_core_clkgen_chk
  import ccg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_W    = 9,
  parameter int SEL_W  = 2
) (
  input logic              xtal_clk,
  input logic              src_clk,
  input logic              rst_n,
  input logic              x_rst_n,
  input logic              s_rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              src_sel,
  input logic              out_sel,
  input logic [SEL_W-1:0]  div_sel,
  input logic [N_W-1:0]    div_n,
  input logic [1:0]        src_en,
  input logic [1:0]        out_en,
  input logic [N_W:0]      div_ratio,
  input logic              div_clk
);
  logic wr_ctrl, wr_ratio, wr_other;
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(CTRL_OFF));
  assign wr_ratio = reg_wr && (reg_addr == ADDR_W'(RATIO_OFF));
  assign wr_other = reg_wr && !wr_ctrl && !wr_ratio;

  // R1
  reset_fields_zero_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    $rose(x_rst_n) |-> (!src_sel && !out_sel && div_sel == '0 && div_n == '0));

  // R2
  ctrl_write_chk: assert property (@(posedge xtal_clk) disable iff (!x_rst_n)
    wr_ctrl |=> (src_sel == $past(reg_wdata[SRC_BIT]) && out_sel == $past(reg_wdata[OUT_BIT])
                 && div_sel == $past(reg_wdata[SEL_LSB +: SEL_W]) && $stable(div_n)));

  // R2
  ratio_write_chk: assert property (@(posedge xtal_clk) disable iff (!x_rst_n)
    wr_ratio |=> (div_n == $past(reg_wdata[N_LSB +: N_W]) && $stable({src_sel, out_sel, div_sel})));

  // R2
  stray_write_chk: assert property (@(posedge xtal_clk) disable iff (!x_rst_n)
    wr_other |=> $stable({src_sel, out_sel, div_sel, div_n}));

  // R9
  src_en_excl_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n) $onehot0(src_en));

  // R9
  out_en_excl_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n) $onehot0(out_en));

  // R5
  zero_ratio_low_chk: assert property (@(posedge src_clk) disable iff (!s_rst_n)
    (div_ratio == '0) |-> !div_clk);
endmodule

bind ccg_core_clkgen ccg_core_clkgen_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W), .SEL_W(SEL_W)
) chk_i (
  .xtal_clk(xtal_clk), .src_clk(src_clk), .rst_n(rst_n), .x_rst_n(x_rst_n),
  .s_rst_n(s_rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .src_sel(src_sel), .out_sel(out_sel), .div_sel(div_sel), .div_n(div_n),
  .src_en(src_en), .out_en(out_en), .div_ratio(div_ratio), .div_clk(div_clk)
);

// File: tb/ccg_core_clkgen_tb_top.sv
`timescale 1ns/1ps
module ccg_core_clkgen_tb_top;
  localparam real CLK_PERIOD = 20.0;
  localparam real PLL_PERIOD = 6.0;
  localparam real TOL        = 0.05;

  logic        xtal_clk, pll_clk, rst_n, reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        core_clk;

  int  checks = 0;
  int  fails  = 0;
  real min_hi = 1.0e9;
  real min_lo = 1.0e9;
  real last_edge = 0.0;
  bit  mon_on = 1'b0;
  bit  have_edge = 1'b0;

  ccg_core_clkgen dut_i (
    .xtal_clk(xtal_clk), .pll_clk(pll_clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_clk(core_clk));

  initial begin
    xtal_clk = 1'b0;
    forever #(CLK_PERIOD / 2.0) xtal_clk = ~xtal_clk;
  end

  initial begin
    pll_clk = 1'b0;
    #1.3;
    forever #(PLL_PERIOD / 2.0) pll_clk = ~pll_clk;
  end

  // Pulse-width monitor on core_clk
  always @(core_clk) begin
    if (mon_on) begin
      if (have_edge) begin
        if (core_clk) begin
          if ($realtime - last_edge < min_lo) min_lo = $realtime - last_edge;
        end else begin
          if ($realtime - last_edge < min_hi) min_hi = $realtime - last_edge;
        end
      end
      have_edge = 1'b1;
      last_edge = $realtime;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < TOL) && (b - a < TOL);
  endfunction

  function automatic logic [31:0] ctrl_word(input bit out_b, input bit src_b, input int sel);
    return (32'(out_b) << 7) | (32'(sel) << 2) | 32'(src_b);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge xtal_clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge xtal_clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge xtal_clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic meas(output real per, output real hi);
    real t0, t1, t2;
    repeat (3) @(posedge core_clk);
    t0 = $realtime;
    @(negedge core_clk);
    t1 = $realtime;
    @(posedge core_clk);
    t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic check_rate(input string req, input real exp_per, input real exp_hi);
    real per, hi;
    meas(per, hi);
    chk(near(per, exp_per), req, "period", per, exp_per);
    chk(near(hi, exp_hi), req, "high time", hi, exp_hi);
  endtask

  initial begin
    repeat (100000) @(posedge xtal_clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int edges;
    int n_list [5] = '{1, 2, 5, 37, 511};
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    #100;
    @(negedge xtal_clk);
    rst_n = 1'b1;
    #200;

    // R1: reset state
    rd(8'h40, d); chk(d == 32'h0, "R1", "ctrl reset", real'(d), 0.0);
    rd(8'h00, d); chk(d == 32'h0, "R1", "ratio reset", real'(d), 0.0);
    check_rate("R1", CLK_PERIOD, CLK_PERIOD / 2.0);

    // R2: field masking, stray offset
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk(d == 32'h1FF0_0000, "R2", "ratio mask", real'(d), real'(32'h1FF0_0000));
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); chk(d == 32'h0000_008D, "R2", "ctrl mask", real'(d), real'(32'h8D));
    wr(8'h40, 32'h0);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, d); chk(d == 32'h0, "R2", "stray read", real'(d), 0.0);
    rd(8'h40, d); chk(d == 32'h0, "R2", "ctrl after stray", real'(d), 0.0);
    wr(8'h00, 32'h0);
    #400;

    mon_on = 1'b1;

    // R7, R8, R3: PLL source, direct ratios
    wr(8'h40, ctrl_word(0, 1, 0)); #200;
    wr(8'h40, ctrl_word(1, 1, 0)); #200;
    check_rate("R3", PLL_PERIOD, PLL_PERIOD / 2.0);
    wr(8'h40, ctrl_word(1, 1, 1)); #200;
    check_rate("R3", 2.0 * PLL_PERIOD, PLL_PERIOD);
    wr(8'h40, ctrl_word(1, 1, 2)); #200;
    check_rate("R3", 3.0 * PLL_PERIOD, PLL_PERIOD);

    // R4: even ratios 2N
    wr(8'h00, 32'(1) << 20);
    wr(8'h40, ctrl_word(1, 1, 3)); #200;
    foreach (n_list[i]) begin
      wr(8'h00, 32'(n_list[i]) << 20); #200;
      check_rate("R4", 2.0 * n_list[i] * PLL_PERIOD, n_list[i] * PLL_PERIOD);
    end

    // R5: N = 0 parks the output low, nonzero N restarts it
    wr(8'h00, 32'h0);
    #(2.0 * 511 * PLL_PERIOD + 200.0);
    edges = 0;
    fork
      begin : cnt_edges
        forever begin @(posedge core_clk); edges++; end
      end
      #500;
    join_any
    disable cnt_edges;
    chk(edges == 0, "R5", "edges while parked", real'(edges), 0.0);
    chk(core_clk == 1'b0, "R5", "parked level", real'(core_clk), 0.0);
    wr(8'h00, 32'(3) << 20); #200;
    check_rate("R5", 6.0 * PLL_PERIOD, 3.0 * PLL_PERIOD);

    // R8, R7, R10: retune order through the crystal
    wr(8'h40, ctrl_word(0, 1, 3)); #200;
    check_rate("R8", CLK_PERIOD, CLK_PERIOD / 2.0);
    wr(8'h40, ctrl_word(0, 0, 1)); #300;
    wr(8'h40, ctrl_word(1, 0, 1)); #300;
    check_rate("R7", 2.0 * CLK_PERIOD, CLK_PERIOD);
    wr(8'h40, ctrl_word(0, 0, 1)); #300;
    wr(8'h40, ctrl_word(0, 1, 1)); #300;
    wr(8'h40, ctrl_word(1, 1, 1)); #300;
    check_rate("R10", 2.0 * PLL_PERIOD, PLL_PERIOD);
    rd(8'h40, d);
    chk(d == ctrl_word(1, 1, 1), "R10", "ctrl readback", real'(d), real'(ctrl_word(1, 1, 1)));

    // R6, R8: no runt across any switch or ratio change
    chk(min_hi > PLL_PERIOD / 2.0 - TOL, "R6", "min high pulse", min_hi, PLL_PERIOD / 2.0);
    chk(min_lo > PLL_PERIOD / 2.0 - TOL, "R8", "min low pulse", min_lo, PLL_PERIOD / 2.0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule